// File: doc/BRIEF.md
# Frame Buffer Streaming Read Master

This block pulls an image frame out of memory and streams it into a pixel FIFO. It drives a pipelined memory-mapped read port (address, read, waitrequest, readdata, readdatavalid). Commands are issued back to back, without waiting for earlier data to return. The address advances one word per accepted command. After the configured last word it jumps back to the configured first word, so frames repeat without any software action.

Returned words pass straight through to the FIFO write port. A FIFO fill-level input throttles fetching in two ways. A hysteresis band between a high and a low threshold starts and stops the stream. A count of reads still in flight guarantees that responses never overflow the FIFO. A go input gates all activity. When go drops, no new commands are issued, but responses already requested are still forwarded. The next run starts again from the first word of the frame.

Top module: `fbdma_reader`

## Requirements
- R1: The first command after go is raised (following at least one idle cycle with no command pending) carries the start address. Each accepted command that is not at the end address is followed by an address larger by DW/8 (4 for 32-bit words).
- R2: After a command at the configured end address is accepted, the next address is the start address. This also holds when start equals end.
- R3: Several reads may be outstanding at once. When waitrequest is low and go, the hysteresis state and the credit all allow it, a read is presented on every cycle.
- R4: While read is high and waitrequest is high, read stays high and the address stays unchanged on the next cycle.
- R5: In each cycle where readdatavalid is high, fifo_wr is high and fifo_wdata equals readdata. Words appear in the order the addresses were accepted. fifo_wr is low in all other cycles.
- R6: go is sampled by a register. A new command is issued on cycle t+1 only if go was high in cycles t-1 and t. With go low, the responses still pending are forwarded to the FIFO.
- R7: Fetching is disabled in a cycle where fifo_level > hi and enabled where fifo_level < lo. In between, the previous setting is kept. The setting after reset is enabled. A new command on cycle t+1 requires the setting of cycle t to be enabled.
- R8: A new command on cycle t+1 requires fifo_level + outstanding + accepted-this-cycle + 1 <= FIFO_DEPTH at cycle t. The FIFO therefore never holds more than FIFO_DEPTH words.
- R9: During reset, read and fifo_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_go | input | 1 | Run enable |
| cfg_start | input | AW | First word address of the frame |
| cfg_end | input | AW | Last word address of the frame |
| cfg_hi | input | LW | Upper fill threshold (stop) |
| cfg_lo | input | LW | Lower fill threshold (resume), below cfg_hi |
| fifo_level | input | LW | Current FIFO occupancy in words |
| mem_addr | output | AW | Read address |
| mem_read | output | 1 | Read command |
| mem_waitreq | input | 1 | Memory not ready to accept the command |
| mem_rdata | input | DW | Returned read data |
| mem_rdvalid | input | 1 | Returned data valid |
| fifo_wr | output | 1 | FIFO write request |
| fifo_wdata | output | DW | FIFO write data |

## Verification
The bench runs a small 16-word FIFO against a memory model in several settings: no backpressure with a fixed latency, random waitrequest with latency varying from 1 to 4, a stalled FIFO drain, and a one-word frame. The fixed-latency run separates pipelined issue from a stop-and-wait master. Random waitrequest shows whether the command is held during a stall. The stalled drain pushes fill level through both thresholds and into the credit limit, so hysteresis and overflow protection can be told apart. Dropping go in the middle of the stream and restarting with a new frame checks response draining and address reload. On every cycle the bench predicts from its own arithmetic whether a read is presented.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fbdma_state_e;
endpackage

// File: rtl/fbdma_addr_gen.sv
module fbdma_addr_gen #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_n;
  logic          at_end;

  assign at_end = (addr == cfg_end);

  always_comb begin
    addr_n = addr;
    if (adv) begin
      if (at_end) addr_n = cfg_start;
      else        addr_n = addr + AW'(STEP);
    end else if (load) begin
      addr_n = cfg_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr <= '0;
    else if (adv || load)  addr <= addr_n;
  end
endmodule

// File: rtl/fbdma_inflight.sv
module fbdma_inflight #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (inc && !dec)      cnt_n = cnt + CW'(1);
    else if (!inc && dec) cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (inc != dec) cnt <= cnt_n;
  end
endmodule

// File: rtl/fbdma_hyst.sv
module fbdma_hyst #(
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] hi,
  input  logic [LW-1:0] lo,
  output logic          fetch_ok
);
  logic fe_q;

  always_comb begin
    fetch_ok = fe_q;
    if (level > hi)      fetch_ok = 1'b0;
    else if (level < lo) fetch_ok = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fe_q <= 1'b1;
    else        fe_q <= fetch_ok;
  end
endmodule

// File: rtl/fbdma_reader.sv
module fbdma_reader
  import fbdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4096,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_go,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic [LW-1:0] cfg_hi,
  input  logic [LW-1:0] cfg_lo,
  input  logic [LW-1:0] fifo_level,
  output logic [AW-1:0] mem_addr,
  output logic          mem_read,
  input  logic          mem_waitreq,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdvalid,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata
);
  localparam int STEP = DW / 8;
  localparam int SW   = LW + 2;

  logic [1:0]    rst_sync;
  logic          rst_q_n;
  fbdma_state_e  st, st_n;
  logic          accept, hold, fetch_ok, room, rd_n, reload;
  logic [LW-1:0] out_cnt;
  logic [SW-1:0] demand;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign accept = mem_read & ~mem_waitreq;
  assign hold   = mem_read &  mem_waitreq;
  assign reload = (st == ST_IDLE) & ~mem_read;

  always_comb begin
    st_n = cfg_go ? ST_RUN : ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) st <= ST_IDLE;
    else          st <= st_n;
  end

  // words committed to the FIFO if one more command is issued
  assign demand = SW'(fifo_level) + SW'(out_cnt) + SW'(accept) + SW'(1);
  assign room   = (demand <= SW'(FIFO_DEPTH));

  always_comb begin
    rd_n = hold | ((st == ST_RUN) & cfg_go & fetch_ok & room);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) mem_read <= 1'b0;
    else          mem_read <= rd_n;
  end

  fbdma_addr_gen #(.AW(AW), .STEP(STEP)) u_addr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .adv       (accept),
    .load      (reload),
    .cfg_start (cfg_start),
    .cfg_end   (cfg_end),
    .addr      (mem_addr)
  );

  fbdma_inflight #(.CW(LW)) u_inflight (
    .clk   (clk),
    .rst_n (rst_q_n),
    .inc   (accept),
    .dec   (mem_rdvalid),
    .cnt   (out_cnt)
  );

  fbdma_hyst #(.LW(LW)) u_hyst (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .level    (fifo_level),
    .hi       (cfg_hi),
    .lo       (cfg_lo),
    .fetch_ok (fetch_ok)
  );

  assign fifo_wr    = mem_rdvalid;
  assign fifo_wdata = mem_rdata;
endmodule

// File: rtl/fbdma_reader_chk.sv
module fbdma_reader_chk #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4096,
  parameter int LW         = 13
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          cfg_go,
  input logic [AW-1:0] cfg_start,
  input logic [AW-1:0] cfg_end,
  input logic [LW-1:0] cfg_hi,
  input logic [LW-1:0] fifo_level,
  input logic [AW-1:0] mem_addr,
  input logic          mem_read,
  input logic          mem_waitreq,
  input logic [LW-1:0] out_cnt
);
  localparam int STEP = DW / 8;

  // R4
  a_r4_hold_cmd: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_read && mem_waitreq) |=> (mem_read && $stable(mem_addr)));

  // R1
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_read && !mem_waitreq && mem_addr != cfg_end)
      |=> (mem_addr == $past(mem_addr) + AW'(STEP)));

  // R2
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_read && !mem_waitreq && mem_addr == cfg_end)
      |=> (mem_addr == $past(cfg_start)));

  // R6
  a_r6_go_gate: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!cfg_go && !(mem_read && mem_waitreq)) |=> !mem_read);

  // R7
  a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fifo_level > cfg_hi && !(mem_read && mem_waitreq)) |=> !mem_read);

  // R8
  a_r8_inflight_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    (LW'(FIFO_DEPTH) >= out_cnt));
endmodule

bind fbdma_reader fbdma_reader_chk #(
  .AW(AW), .DW(DW), .FIFO_DEPTH(FIFO_DEPTH), .LW(LW)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .cfg_go      (cfg_go),
  .cfg_start   (cfg_start),
  .cfg_end     (cfg_end),
  .cfg_hi      (cfg_hi),
  .fifo_level  (fifo_level),
  .mem_addr    (mem_addr),
  .mem_read    (mem_read),
  .mem_waitreq (mem_waitreq),
  .out_cnt     (out_cnt)
);

// File: tb/fbdma_reader_test.sv
module fbdma_reader_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int D  = 16;
  localparam int LW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_go = 1'b0;
  logic [AW-1:0] cfg_start = 16'h0100;
  logic [AW-1:0] cfg_end = 16'h011C;
  logic [LW-1:0] cfg_hi = LW'(12);
  logic [LW-1:0] cfg_lo = LW'(4);
  logic [LW-1:0] fifo_level;
  logic [AW-1:0] mem_addr;
  logic          mem_read;
  logic          mem_waitreq;
  logic [DW-1:0] mem_rdata;
  logic          mem_rdvalid;
  logic          fifo_wr;
  logic [DW-1:0] fifo_wdata;

  always #5 clk = ~clk;

  fbdma_reader #(.AW(AW), .DW(DW), .FIFO_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_go(cfg_go), .cfg_start(cfg_start),
    .cfg_end(cfg_end), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .fifo_level(fifo_level), .mem_addr(mem_addr), .mem_read(mem_read),
    .mem_waitreq(mem_waitreq), .mem_rdata(mem_rdata),
    .mem_rdvalid(mem_rdvalid), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // ---------------- memory and FIFO model (posedge, nonblocking) -------
  bit        rand_wait = 1'b0;
  bit        var_lat = 1'b0;
  bit        drain = 1'b1;
  logic [15:0] lfsr;
  int        cyc;
  logic [AW-1:0] q_addr [32];
  int        q_due [32];
  int        wp, rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1; cyc <= 0; wp <= 0; rp <= 0;
      mem_waitreq <= 1'b0; mem_rdvalid <= 1'b0; mem_rdata <= '0;
      fifo_level <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc <= cyc + 1;
      mem_waitreq <= rand_wait ? (lfsr[2] & lfsr[7]) | lfsr[11] & lfsr[4] : 1'b0;
      if (mem_read && !mem_waitreq) begin
        q_addr[wp % 32] <= mem_addr;
        q_due[wp % 32]  <= cyc + (var_lat ? 1 + int'(lfsr[6:5]) : 3);
        wp <= wp + 1;
      end
      if (rp != wp && cyc >= q_due[rp % 32]) begin
        mem_rdvalid <= 1'b1;
        mem_rdata   <= word_of(q_addr[rp % 32]);
        rp <= rp + 1;
      end else begin
        mem_rdvalid <= 1'b0;
      end
      fifo_level <= fifo_level + LW'(mem_rdvalid)
                  - LW'(drain && fifo_level != '0);
    end
  end

  // ---------------- monitor (negedge, independent prediction) ----------
  bit            mon_on = 1'b0;
  bit            have_prev = 1'b0;
  bit            exp_rd, prev_hold, go_d1 = 1'b0, fe = 1'b1;
  logic [AW-1:0] prev_addr, exp_a;
  logic [AW-1:0] m_q [32];
  int            mw = 0, mr = 0, out_b = 0, max_out = 0, wraps = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit acc, hld, room;
      acc = mem_read && !mem_waitreq;
      hld = mem_read && mem_waitreq;
      if (have_prev) begin
        chk(mem_read == exp_rd, "R7 read issue (R3 R6 R8)", mem_read, exp_rd);
        if (prev_hold) chk(mem_read && mem_addr == prev_addr, "R4 hold", mem_addr, prev_addr);
      end
      if (fifo_level > cfg_hi) fe = 1'b0;
      else if (fifo_level < cfg_lo) fe = 1'b1;
      room = (int'(fifo_level) + out_b + int'(acc) + 1) <= D;
      exp_rd = hld || (cfg_go && go_d1 && fe && room);
      if (acc) begin
        chk(mem_addr == exp_a, "R1 address", mem_addr, exp_a);
        if (exp_a == cfg_end) begin exp_a = cfg_start; wraps++; end
        else exp_a = exp_a + AW'(4);
        m_q[mw % 32] = mem_addr; mw++;
      end
      chk(fifo_wr == mem_rdvalid, "R5 write strobe", fifo_wr, mem_rdvalid);
      if (fifo_wr) begin
        chk(fifo_wdata == word_of(m_q[mr % 32]), "R5 data order",
            fifo_wdata, word_of(m_q[mr % 32]));
        mr++;
      end
      chk(int'(fifo_level) <= D, "R8 fifo bound", fifo_level, D);
      out_b = out_b + int'(acc) - int'(fifo_wr);
      if (out_b > max_out) max_out = out_b;
      go_d1 = cfg_go; prev_hold = hld; prev_addr = mem_addr; have_prev = 1'b1;
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_run();
    exp_a = cfg_start;
    cfg_go = 1'b1;
  endtask

  task automatic stop_run();
    cfg_go = 1'b0;
    step(2);
    while (out_b != 0) step(1);
    step(4);
    chk(!mem_read && out_b == 0, "R6 drained idle", mem_read, 0);
  endtask

  initial begin
    step(3);
    chk(mem_read == 1'b0, "R9 reset read", mem_read, 0);
    chk(fifo_wr == 1'b0, "R9 reset write", fifo_wr, 0);
    rst_n = 1'b1;
    step(1);
    mon_on = 1'b1;
    step(5);

    // A: no backpressure, fixed latency, 8-word frame
    start_run(); step(300); stop_run();
    chk(max_out >= 2, "R3 pipelined", max_out, 2);
    chk(wraps > 0, "R2 wrap seen", wraps, 1);

    // B: random waitrequest and latency
    rand_wait = 1'b1; var_lat = 1'b1; cfg_start = 16'h0400; cfg_end = 16'h043C;
    step(2); start_run(); step(600); stop_run();

    // C: drain stalled, then resumed
    drain = 1'b0; cfg_start = 16'h0800; cfg_end = 16'h0890;
    step(2); start_run(); step(200);
    chk(!mem_read || mem_waitreq, "R7 stalled stop", mem_read, 0);
    drain = 1'b1; step(300);
    rand_wait = 1'b0; drain = 1'b0; step(150);
    drain = 1'b1; step(200); stop_run();

    // D: single-word frame, start equals end
    wraps = 0; rand_wait = 1'b1; cfg_start = 16'h0200; cfg_end = 16'h0200;
    step(2); start_run(); step(200); stop_run();
    chk(wraps > 0, "R2 single word", wraps, 1);

    // E: go toggled mid-stream, reload on restart
    var_lat = 1'b0; cfg_start = 16'h0300; cfg_end = 16'h031C;
    step(2); start_run(); step(13); stop_run();
    start_run(); step(100); stop_run();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule